// File: doc/BRIEF.md
# Serial Flash Status Register Responder

This block is the device-side command handler for the status register of a serial flash memory. It listens on a serial input that is sampled on each rising clock edge while an active-low chip select is held low. The first eight bits of a frame form a command byte. Three commands are recognised: set the write-enable latch, write the status register, and read the status register back on a serial output.

The status register holds a write-in-progress (busy) flag, the write-enable latch and three block-protect bits. The block-protect bits are also presented as a parallel output so that the array logic can treat the guarded sectors as read-only. A status write takes effect only if the latch is set and chip select returns high exactly after the sixteenth bit of the frame. An accepted write starts a self-timed busy interval, counted in clock cycles, and the busy flag is visible in the register for that interval.

The serial clock drives the whole block and is assumed to run without pause, also while chip select is high, so that the busy interval keeps counting. The serial output has a separate enable that a pad driver uses to float the line.

Top module: `flash_status_responder`

## Requirements
- R1: After reset the status byte is 8'h00, the protect output is 3'b000, and the output enable and serial output are both low.
- R2: Command byte 8'h06, sent while the busy flag is clear, sets the write-enable latch, which is status bit 1.
- R3: Command byte 8'h01 followed by one data byte, both MSB first, with chip select rising right after the sixteenth bit and the latch set, loads data bits 4:2 into the protect bits (status bits 4:2). The update is visible after the first clock edge at which chip select is high. No other data bit changes the status, and status bits 7:5 always read 0.
- R4: A status write sent while the write-enable latch is clear leaves the protect bits unchanged.
- R5: A status write whose frame ends after fewer or more than sixteen bits leaves the protect bits unchanged.
- R6: An accepted status write sets the busy flag (status bit 0) for exactly BUSY_CYCLES clock cycles, counted from the edge that takes the write. At the end of that interval the busy flag and the write-enable latch both clear.
- R7: While the busy flag is set, write-enable and status-write commands have no effect. A read-status command still returns the live register.
- R8: Command byte 8'h05 drives the status register MSB first. Bit 7 is valid after the edge that takes the eighth command bit, and one bit follows per clock. The byte repeats for as long as chip select stays low, and each bit shows the register's current value.
- R9: The output enable is high only while status data is being shifted out. Whenever the enable is low, the serial output is low.
- R10: Any other command byte causes no output and no change of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select that frames a command |
| sdi | input | 1 | Serial command and data input, MSB first |
| sdo | output | 1 | Serial status output |
| sdo_en | output | 1 | Output enable for the pad driver; the line floats when low |
| prot_bits | output | 3 | Current block-protect bits |

## Verification
All results come from registers. A status bit for a read appears one edge after the bit period that ends the command byte, and then one bit per clock. The protect bits and the busy flag change on the first edge at which chip select is high after a valid write. The busy flag drops BUSY_CYCLES edges later. The bench drives each input on a falling edge and samples on the next falling edge, so it sees exactly one new register value per rising edge. For the busy window, one long read frame is held open across the end of the interval, and the bench predicts from BUSY_CYCLES which repeated byte first shows the flag and the latch cleared.

// File: rtl/fsr_pkg.sv
// Package: command codes, status bit positions and frame phases that the
// responder modules share.
package fsr_pkg;
    localparam logic [7:0] OP_SET_WEL  = 8'h06;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;

    localparam int STAT_W   = 8;
    localparam int PROT_W   = 3;
    localparam int BIT_WIP  = 0;
    localparam int BIT_WEL  = 1;
    localparam int PROT_LSB = 2;

    typedef enum logic [2:0] {
        PH_CMD,     // collecting command byte
        PH_DATA,    // collecting status-write data byte
        PH_ARMED,   // 16 bits seen; waiting for chip select to rise
        PH_READ,    // shifting status out
        PH_SKIP     // rest of frame ignored
    } phase_t;
endpackage

// File: rtl/fsr_frame_rx.sv
// Frame receiver: shifts in serial bits while chip select is low, decodes
// the command byte and emits single-cycle requests.
// Assumes: chip select is high for at least one clock edge between frames.
module fsr_frame_rx
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              wel_set_req,
    output logic              rd_start,
    output logic              rd_active,
    output logic              commit_req,
    output logic [STAT_W-1:0] wr_byte
);
    localparam int CNT_W = $clog2(STAT_W);

    phase_t             phase;
    logic [CNT_W-1:0]   bit_idx;
    logic [STAT_W-2:0]  shreg;
    logic [STAT_W-1:0]  byte_now;
    logic               byte_done;

    assign byte_now  = {shreg, sdi};
    assign byte_done = !cs_n && (bit_idx == CNT_W'(STAT_W - 1));

    // Decoded requests seen by the status register and output shifter
    always_comb begin
        wel_set_req = byte_done && (phase == PH_CMD) && (byte_now == OP_SET_WEL);
        rd_start    = byte_done && (phase == PH_CMD) && (byte_now == OP_RD_STAT);
        rd_active   = !cs_n && (phase == PH_READ);
        commit_req  = cs_n && (phase == PH_ARMED);
    end

    // Bit counter, shift register and phase tracking across a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CMD;
            bit_idx <= '0;
            shreg   <= '0;
            wr_byte <= '0;
        end else if (cs_n) begin
            phase   <= PH_CMD;
            bit_idx <= '0;
        end else begin
            shreg   <= byte_now[STAT_W-2:0];
            bit_idx <= bit_idx + 1'b1;
            case (phase)
                PH_CMD: begin
                    if (byte_done) begin
                        if (byte_now == OP_WR_STAT)      phase <= PH_DATA;
                        else if (byte_now == OP_RD_STAT) phase <= PH_READ;
                        else                             phase <= PH_SKIP;
                    end
                end
                PH_DATA: begin
                    if (byte_done) begin
                        wr_byte <= byte_now;
                        phase   <= PH_ARMED;
                    end
                end
                PH_ARMED: phase <= PH_SKIP;
                default:  phase <= phase;
            endcase
        end
    end
endmodule

// File: rtl/fsr_status_reg.sv
// Status register: write-enable latch, protect bits and the self-timed
// busy counter. Requests arrive as single-cycle pulses.
// Assumes: BUSY_CYCLES >= 1; commit and latch-set never coincide.
module fsr_status_reg
    import fsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_req,
    input  logic              commit_req,
    input  logic [PROT_W-1:0] new_prot,
    output logic [STAT_W-1:0] status,
    output logic              wip,
    output logic              wel,
    output logic [PROT_W-1:0] prot
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] busy_cnt;

    assign wip = (busy_cnt != '0);

    // Assemble the readable status byte; upper bits are fixed at zero
    always_comb begin
        status                           = '0;
        status[BIT_WIP]                  = wip;
        status[BIT_WEL]                  = wel;
        status[PROT_LSB +: PROT_W]       = prot;
    end

    // Latch, protect bits and busy countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            wel      <= 1'b0;
            prot     <= '0;
        end else if (wip) begin
            busy_cnt <= busy_cnt - 1'b1;
            if (busy_cnt == CW'(1)) wel <= 1'b0;
        end else begin
            if (commit_req && wel) begin
                prot     <= new_prot;
                busy_cnt <= CW'(BUSY_CYCLES);
            end
            if (wel_set_req) wel <= 1'b1;
        end
    end
endmodule

// File: rtl/fsr_shift_out.sv
// Output shifter: presents the live status register MSB first, wrapping
// every byte, while a read frame is open.
module fsr_shift_out
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_start,
    input  logic              rd_active,
    input  logic [STAT_W-1:0] status,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int IW = $clog2(STAT_W);

    logic [IW-1:0] idx;

    // Drive one status bit per clock; release the line between frames
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
            idx    <= '0;
        end else if (rd_start) begin
            sdo    <= status[STAT_W-1];
            sdo_en <= 1'b1;
            idx    <= IW'(STAT_W - 2);
        end else if (rd_active) begin
            sdo    <= status[idx];
            idx    <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/flash_status_responder.sv
// Top: serial flash status-register command responder.
// Assumes: clk runs continuously so the busy interval elapses between frames.
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    output logic [PROT_W-1:0] prot_bits
);
    logic              wel_set_req;
    logic              rd_start;
    logic              rd_active;
    logic              commit_req;
    logic [STAT_W-1:0] wr_byte;
    logic [STAT_W-1:0] status;
    logic              wip;
    logic              wel;

    fsr_frame_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sdi         (sdi),
        .wel_set_req (wel_set_req),
        .rd_start    (rd_start),
        .rd_active   (rd_active),
        .commit_req  (commit_req),
        .wr_byte     (wr_byte)
    );

    fsr_status_reg #(.BUSY_CYCLES(BUSY_CYCLES)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wel_set_req (wel_set_req),
        .commit_req  (commit_req),
        .new_prot    (wr_byte[PROT_LSB +: PROT_W]),
        .status      (status),
        .wip         (wip),
        .wel         (wel),
        .prot        (prot_bits)
    );

    fsr_shift_out u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_start  (rd_start),
        .rd_active (rd_active),
        .status    (status),
        .sdo       (sdo),
        .sdo_en    (sdo_en)
    );
endmodule

// File: rtl/fsr_checker.sv
// Checker: temporal properties of the responder, bound into the top.
module fsr_checker #(
    parameter int BUSY_CYCLES = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo,
    input logic       sdo_en,
    input logic [2:0] prot_bits,
    input logic       wip,
    input logic       wel
);
    int unsigned busy_len;

    // Count consecutive busy cycles to check the interval length
    always_ff @(posedge clk) begin
        if (!rst_n || !wip) busy_len <= 0;
        else                busy_len <= busy_len + 1;
    end

    assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);
    assert_release_on_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_en);
    assert_prot_at_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_bits) |-> ($past(cs_n) && $past(wel) && !$past(wip)));
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_n));
    assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (busy_len == BUSY_CYCLES));
    assert_latch_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
    assert_no_latch_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wip) |-> !$rose(wel));
endmodule

bind flash_status_responder fsr_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .prot_bits (prot_bits),
    .wip       (wip),
    .wel       (wel)
);

// File: tb/flash_status_responder_tb.sv
module flash_status_responder_tb;
    localparam int B = 40;   // must exceed about 20 for the busy tests

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_en;
    logic [2:0] prot_bits;

    int total = 0;
    int bad = 0;
    logic [7:0] rd_buf [8];
    logic       rd_en_ok;

    always #4 clk = ~clk;   // 125 MHz

    flash_status_responder #(.BUSY_CYCLES(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .prot_bits(prot_bits)
    );

    // Vector: {cmd[25:18], data[17:10], nbits[9:5], wren[4], exp_prot[3:1], exp_wel[0]}
    localparam logic [25:0] VEC [7] = '{
        {8'h01, 8'b000_101_00, 5'd16, 1'b1, 3'd5, 1'b0},  // R3 accepted
        {8'h01, 8'b000_010_00, 5'd16, 1'b0, 3'd5, 1'b0},  // R4 no latch
        {8'h01, 8'b000_011_00, 5'd15, 1'b1, 3'd5, 1'b1},  // R5 short
        {8'h01, 8'b000_011_00, 5'd17, 1'b1, 3'd5, 1'b1},  // R5 long
        {8'h01, 8'b111_110_11, 5'd16, 1'b1, 3'd6, 1'b0},  // R3 other bits ignored
        {8'hA5, 8'hFF,         5'd16, 1'b1, 3'd6, 1'b1},  // R10 unknown
        {8'h01, 8'h00,         5'd16, 1'b1, 3'd0, 1'b0}   // R3 clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [23:0] word, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_n = 1'b0;
            sdi  = word[23 - i];
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs_n = 1'b1;
        sdi  = 1'b0;
    endtask

    task automatic rdsr(input int nbytes);
        rd_en_ok = 1'b1;
        send_bits({8'h05, 16'h0}, 8);
        for (int m = 0; m < nbytes; m++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                cs_n = 1'b0;
                sdi  = 1'b0;
                rd_buf[m][7 - b] = sdo;
                if (sdo_en !== 1'b1) rd_en_ok = 1'b0;
            end
        end
        end_frame();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [25:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 prot", {29'b0, prot_bits}, 32'h0);
        check("R1 sdo_en", {31'b0, sdo_en}, 32'h0);
        check("R1 sdo", {31'b0, sdo}, 32'h0);
        rdsr(1);
        check("R1 status", {24'b0, rd_buf[0]}, 32'h00);
        check("R8 enable during read", {31'b0, rd_en_ok}, 32'h1);
        idle(1);
        check("R9 released after read", {31'b0, sdo_en}, 32'h0);

        // R2: latch set
        send_bits({8'h06, 16'h0}, 8);
        end_frame();
        rdsr(2);
        check("R2 latch", {24'b0, rd_buf[0]}, 32'h02);
        check("R8 repeat", {24'b0, rd_buf[1]}, 32'h02);

        // Vector walk
        for (int k = 0; k < 7; k++) begin
            v = VEC[k];
            if (v[4]) begin
                send_bits({8'h06, 16'h0}, 8);
                end_frame();
            end
            send_bits({v[25:10], 8'h00}, int'(v[9:5]));
            end_frame();
            idle(B + 4);
            check($sformatf("R3/R4/R5/R10 vec%0d prot", k), {29'b0, prot_bits}, {29'b0, v[3:1]});
            rdsr(1);
            check($sformatf("R3/R4/R5/R10 vec%0d status", k), {24'b0, rd_buf[0]},
                  {24'b0, 3'b000, v[3:1], v[0], 1'b0});
        end

        // R6/R7: busy window seen through one long read frame
        send_bits({8'h06, 16'h0}, 8);
        end_frame();
        send_bits({8'h01, 8'h0C, 8'h00}, 16);
        end_frame();
        rdsr(6);
        for (int m = 0; m < 6; m++) begin
            logic wip_e;
            logic wel_e;
            wip_e = ((15 + 8 * m) <= B);
            wel_e = ((14 + 8 * m) <= B);
            check($sformatf("R6 R7 busy byte %0d", m), {24'b0, rd_buf[m]},
                  {24'b0, 3'b000, 3'b011, wel_e, wip_e});
        end
        idle(B + 4);

        // R7: status write while busy is ignored
        send_bits({8'h06, 16'h0}, 8);
        end_frame();
        send_bits({8'h01, 8'h04, 8'h00}, 16);
        end_frame();
        send_bits({8'h06, 16'h0}, 8);
        end_frame();
        send_bits({8'h01, 8'h1C, 8'h00}, 16);
        end_frame();
        idle(B + 4);
        check("R7 prot", {29'b0, prot_bits}, 32'h1);
        rdsr(1);
        check("R7 status", {24'b0, rd_buf[0]}, 32'h04);

        // R10/R9: unknown command drives nothing
        send_bits({8'hA5, 16'h0}, 8);
        begin
            logic quiet;
            quiet = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                cs_n = 1'b0;
                sdi  = 1'b1;
                if (sdo_en !== 1'b0 || sdo !== 1'b0) quiet = 1'b0;
            end
            check("R10 R9 no output", {31'b0, quiet}, 32'h1);
        end
        end_frame();
        idle(2);
        rdsr(1);
        check("R10 status", {24'b0, rd_buf[0]}, 32'h04);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule